// File: doc/BRIEF.md
# Eight-to-one tree serializer

This block takes an eight-bit parallel word and sends it out one bit per fast clock cycle, lowest bit first, with no gap between consecutive words. Everything runs on one fast clock. Internally a three-bit phase sequencer stands in for the clock divider. Its half-rate stage toggles every cycle, and its quarter-rate stage advances whenever the half-rate stage wraps. Together they give the one-eighth-rate load strobe. The strobe is also driven out as a true/complement pair, so the upstream source can present each word in step with it.

Serialization is done by a selector tree rather than a shift register. Even input bits (0, 2, 4, 6) go into one 4:1 lane and odd bits (1, 3, 5, 7) into another. Both lanes are stepped by the quarter-rate phase bits and registered. A 2:1 selector, switched by the delayed half-rate bit, then interleaves the two lanes. A final register on the fast clock drives the serial bit and its complement.

The sequencer walks the phase states PH_B0, PH_B1, … PH_B7, one per cycle. The transition PH_B3→PH_B4 raises the divided clock. The wrap PH_B7→PH_B0 is the load transition: it captures the word and lowers the divided clock. Synchronous reset forces PH_B0.

Top module: `ser8_tree_top`

## Requirements
- R1: While `rst` is high, and on the cycle after any edge that samples it high, `ser_o`=0, `ser_n_o`=1, `div8_o`=0 and `div8_n_o`=1. Reset also clears the phase, the captured word and the lane registers.
- R2: `ser_n_o` is always the inverse of `ser_o`, and `div8_n_o` is always the inverse of `div8_o`.
- R3: Count rising edges from the first one with `rst` low as edge 1. After edge n, `div8_o` is 1 when n mod 8 is 4, 5, 6 or 7, and 0 otherwise. The strobe is therefore low for 4 cycles and high for 4 cycles.
- R4: `par_i` is sampled only on edges 8, 16, 24, … (the edges on which `div8_o` falls). A value on `par_i` at any other edge has no effect on `ser_o`.
- R5: Bit k (k = 0…7) of a word captured at edge 8m appears on `ser_o` after edge 8m+k+2. This is a fixed latency of two cycles from capture to bit 0, in the order bit 0 up to bit 7, with back-to-back words following without a gap.
- R6: After reset, `ser_o` stays 0 after edges 1 through 9, because the captured word is cleared.
- R7: A reset in the middle of a stream restarts the edge numbering of R3 to R6 from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| par_i | input | 8 | Parallel word; bit 0 is sent first |
| ser_o | output | 1 | Serial data, true |
| ser_n_o | output | 1 | Serial data, complement |
| div8_o | output | 1 | One-eighth-rate load strobe, true |
| div8_n_o | output | 1 | One-eighth-rate load strobe, complement |

## Verification
The hardest thing to show from the ports is that only the single load edge samples `par_i`. A correct word held steady for all eight cycles would hide a capture made one cycle early or late. The driver therefore puts random junk on `par_i` in every cycle except the one just before the load edge, and only that one word enters the scoreboard. Back-to-back words and a reset in mid-stream then exercise the wrap from bit 7 of one word to bit 0 of the next, and the restart of the phase.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
    localparam int unsigned SER_RATIO = 8;
    localparam int unsigned PH_W      = $clog2(SER_RATIO);
    localparam int unsigned LANES     = 2;
    localparam int unsigned LANE_W    = SER_RATIO / LANES;
    localparam int unsigned QSEL_W    = PH_W - 1;

    typedef enum logic [PH_W-1:0] {
        PH_B0 = 3'd0,
        PH_B1 = 3'd1,
        PH_B2 = 3'd2,
        PH_B3 = 3'd3,
        PH_B4 = 3'd4,
        PH_B5 = 3'd5,
        PH_B6 = 3'd6,
        PH_B7 = 3'd7
    } phase_e;
endpackage

// File: rtl/ser8_clk_div.sv
module ser8_clk_div
    import ser8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_o,
    output logic   load_o,
    output logic   div8_o,
    output logic   div8_n_o
);
    // divide-by-2 stage
    logic              half_q;
    // divide-by-4 stage, enabled when the half stage wraps
    logic [QSEL_W-1:0] quart_q;
    logic              div_set;
    logic              div_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= 1'b0;
            quart_q <= '0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                quart_q <= quart_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_e'({quart_q, half_q});

    // output decode per phase state
    always_comb begin
        div_set = 1'b0;
        div_clr = 1'b0;
        load_o  = 1'b0;
        unique case (phase_o)
            PH_B3:   div_set = 1'b1;
            PH_B7: begin
                div_clr = 1'b1;
                load_o  = 1'b1;
            end
            PH_B0, PH_B1, PH_B2, PH_B4, PH_B5, PH_B6: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div8_o   <= 1'b0;
            div8_n_o <= 1'b1;
        end else if (div_set) begin
            div8_o   <= 1'b1;
            div8_n_o <= 1'b0;
        end else if (div_clr) begin
            div8_o   <= 1'b0;
            div8_n_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ser8_word_cap.sv
module ser8_word_cap
    import ser8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [SER_RATIO-1:0] par_i,
    output logic [SER_RATIO-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
        end else if (load_i) begin
            word_o <= par_i;
        end
    end
endmodule

// File: rtl/ser8_sel_tree.sv
module ser8_sel_tree
    import ser8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SER_RATIO-1:0] word_i,
    input  phase_e               phase_i,
    output logic                 bit_o
);
    logic [PH_W-1:0]   ph;
    logic [QSEL_W-1:0] qsel;
    logic [LANES-1:0]  lane_q;
    logic              half_d;

    assign ph   = phase_i;
    assign qsel = ph[PH_W-1:1];

    // one registered 4:1 lane per parity: lane g carries bits g, g+2, g+4, g+6
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_bits;
        for (genvar j = 0; j < LANE_W; j++) begin : g_tap
            assign lane_bits[j] = word_i[LANES*j + g];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= 1'b0;
            end else begin
                lane_q[g] <= lane_bits[qsel];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_d <= 1'b0;
        end else begin
            half_d <= ph[0];
        end
    end

    // half-rate 2:1 interleave
    assign bit_o = half_d ? lane_q[1] : lane_q[0];
endmodule

// File: rtl/ser8_out_reg.sv
module ser8_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    output logic q_o,
    output logic q_n_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o   <= 1'b0;
            q_n_o <= 1'b1;
        end else begin
            q_o   <= bit_i;
            q_n_o <= ~bit_i;
        end
    end
endmodule

// File: rtl/ser8_tree_top.sv
module ser8_tree_top
    import ser8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] par_i,
    output logic       ser_o,
    output logic       ser_n_o,
    output logic       div8_o,
    output logic       div8_n_o
);
    phase_e                 phase_w;
    logic                   load_w;
    logic [SER_RATIO-1:0]   word_w;
    logic                   tree_bit_w;

    ser8_clk_div div_i (
        .clk      (clk),
        .rst      (rst),
        .phase_o  (phase_w),
        .load_o   (load_w),
        .div8_o   (div8_o),
        .div8_n_o (div8_n_o)
    );

    ser8_word_cap cap_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .par_i  (par_i),
        .word_o (word_w)
    );

    ser8_sel_tree tree_i (
        .clk     (clk),
        .rst     (rst),
        .word_i  (word_w),
        .phase_i (phase_w),
        .bit_o   (tree_bit_w)
    );

    ser8_out_reg out_i (
        .clk   (clk),
        .rst   (rst),
        .bit_i (tree_bit_w),
        .q_o   (ser_o),
        .q_n_o (ser_n_o)
    );
endmodule

// File: rtl/ser8_tree_chk.sv
module ser8_tree_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] par_i,
    input logic       ser_o,
    input logic       ser_n_o,
    input logic       div8_o,
    input logic       div8_n_o,
    input logic       load_i,
    input logic [7:0] word_i
);
    assert_reset_outputs_R1: assert property (@(posedge clk)
        rst |=> (!ser_o && ser_n_o && !div8_o && div8_n_o));

    assert_ser_compl_R2: assert property (@(posedge clk) disable iff (rst)
        ser_n_o == !ser_o);

    assert_div_compl_R2: assert property (@(posedge clk) disable iff (rst)
        div8_n_o == !div8_o);

    assert_div_high_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(div8_o) |-> ($past(div8_o, 4) && !$past(div8_o, 5)));

    assert_div_low_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(div8_o) |-> !$past(div8_o, 4));

    assert_load_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> $fell(div8_o));

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(word_i));

    assert_first_bit_latency_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |-> ##3 (ser_o == $past(par_i[0], 3)));
endmodule

bind ser8_tree_top ser8_tree_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .par_i    (par_i),
    .ser_o    (ser_o),
    .ser_n_o  (ser_n_o),
    .div8_o   (div8_o),
    .div8_n_o (div8_n_o),
    .load_i   (load_w),
    .word_i   (word_w)
);

// File: tb/ser8_tree_top_tb_top.sv
`timescale 1ns/1ps
module ser8_tree_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] par = 8'h00;
    logic       ser_o, ser_n_o, div8_o, div8_n_o;

    int unsigned edge_n;
    bit          exp_q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    ser8_tree_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .par_i    (par),
        .ser_o    (ser_o),
        .ser_n_o  (ser_n_o),
        .div8_o   (div8_o),
        .div8_n_o (div8_n_o)
    );

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)",
                     req, what, act, exp, edge_n);
        end
    endtask

    // monitor: compares outputs against the scoreboard after each edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(ser_n_o == !ser_o, "R2", "ser_n_o vs ~ser_o", ser_n_o, !ser_o);
            check(div8_n_o == !div8_o, "R2", "div8_n_o vs ~div8_o", div8_n_o, !div8_o);
            check(div8_o == ((edge_n % 8) >= 4), "R3", "div8_o", div8_o,
                  int'((edge_n % 8) >= 4));
            if (edge_n >= 1 && edge_n <= 9) begin
                check(ser_o == 1'b0, "R6", "ser_o before first word", ser_o, 0);
            end else if (edge_n >= 10) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "scoreboard empty", ser_o, -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(ser_o == e, "R5", "serial bit (R4 capture)", ser_o, e);
                end
            end
        end
    end

    // driver: junk on par except in the cycle before the load edge
    task automatic send(input logic [7:0] w);
        do begin
            @(negedge clk);
            if (((edge_n + 1) % 8) != 0) par = 8'($urandom);
        end while (((edge_n + 1) % 8) != 0);
        par = w;
        for (int k = 0; k < 8; k++) exp_q.push_back(w[k]);
    endtask

    task automatic drain_and_reset();
        wait (exp_q.size() == 0);
        rst = 1'b1;
        @(negedge clk);
        exp_q.delete();
        @(negedge clk);
        check(ser_o == 1'b0,   "R1", "ser_o in reset",   ser_o,   0);
        check(ser_n_o == 1'b1, "R1", "ser_n_o in reset", ser_n_o, 1);
        check(div8_o == 1'b0,  "R1", "div8_o in reset",  div8_o,  0);
        check(div8_n_o == 1'b1,"R1", "div8_n_o in reset",div8_n_o,1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ser_o == 1'b0 && ser_n_o == 1'b1, "R1", "serial pair at start",
              ser_o, 0);
        check(div8_o == 1'b0 && div8_n_o == 1'b1, "R1", "strobe pair at start",
              div8_o, 0);
        rst = 1'b0;

        // directed patterns: boundaries of bit order
        send(8'h01); send(8'h80); send(8'h00); send(8'hFF);
        send(8'hA5); send(8'h5A); send(8'hFE); send(8'h7F);
        // random back-to-back words
        for (int i = 0; i < 100; i++) send(8'($urandom));
        drain_and_reset();

        // R7: restart after mid-stream reset
        @(negedge clk);
        rst = 1'b0;
        send(8'h3C);
        for (int i = 0; i < 60; i++) send(8'($urandom));
        // reset while the queue is still full
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        exp_q.delete();
        @(negedge clk);
        check(ser_o == 1'b0 && div8_o == 1'b0, "R7", "outputs after mid reset",
              ser_o, 0);
        rst = 1'b0;
        send(8'hC3);
        for (int i = 0; i < 40; i++) send(8'($urandom));
        drain_and_reset();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        done = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule